// File: doc/BRIEF.md
# SPI Flash Boot Image Copier

After reset this block pulls a boot image out of a serial NOR flash and places it in main memory before the processor is allowed to run. It reads a fixed-size header at a known flash offset over an SPI master link. The header carries a signature word, the payload size in bytes, the memory address where the payload goes and the address where execution starts. If the signature matches, the block reads the payload in a second flash transaction and writes it to memory as 32-bit words through a Wishbone master write port.

When the last word has been acknowledged, the block raises a completion flag and the processor run enable, and it presents the entry address as the boot vector. A wrong signature stops the sequence for good. In that case the error flag is raised, no memory write is made, and the processor is held.

Top module: `spi_boot_copier`

## Requirements
- R1: While reset is applied and straight after it, spi_cs_n is high, spi_sclk is low, wb_cyc_o is low, and done, error and cpu_run are all low.
- R2: The first flash transaction lowers spi_cs_n and sends the byte 0x03 and then the 24-bit address 0x080000. It sends MSB first in SPI mode 0: the clock idles low, the flash changes data on the falling edge and it is sampled on the rising edge. It then reads the 64 header bytes.
- R3: If header bytes 0..3, taken big-endian, differ from 0x27051956, error goes high and stays high. done and cpu_run stay low, no Wishbone cycle is made, and spi_cs_n stays high from then on.
- R4: spi_cs_n goes high between the header transaction and the payload transaction. The payload transaction sends 0x03 and then the address 0x080040, the byte that follows the 64-byte header.
- R5: Header bytes 12..15 (big-endian) give the payload length L, and bytes 16..19 give the load address A. Payload bytes are packed big-endian: the earliest byte goes to bits 31:24. Word i is written to address A+4*i with select 4'b1111.
- R6: If L is not a multiple of 4, the last word holds its k valid bytes in the upper lanes and the remaining lanes are zero. Its select is 4'b1000 for k=1, 4'b1100 for k=2 and 4'b1110 for k=3.
- R7: After the ack of the last write, done and cpu_run go high and stay high. boot_vector then equals header bytes 20..23, taken big-endian.
- R8: If L is 0, no payload transaction and no Wishbone cycle take place, and done and cpu_run go high after the header.
- R9: Each write is a single Wishbone cycle. While stb is high without ack, address, data and select hold steady, and the SPI clock stays low with chip select asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| wb_adr_o | output | 32 | Memory write byte address |
| wb_dat_o | output | 32 | Memory write data |
| wb_sel_o | output | 4 | Byte lane selects |
| wb_we_o | output | 1 | Write enable |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_ack_i | input | 1 | Slave acknowledge |
| cpu_run | output | 1 | Processor run enable |
| boot_vector | output | 32 | Entry address from the header |
| done | output | 1 | Copy finished |
| error | output | 1 | Bad image signature |

## Verification
Two events can arrive on the same byte. The arrival of the last payload byte can be both the end of a word and the end of the image, so a partial-word flush and the completion step fall in one write. A second collision is the ack of a word arriving while the SPI engine could go on shifting. The bench provokes the first with payload lengths of 5, 6, 7 and 24 bytes. It provokes the second with slave ack delays of zero and of several cycles. A scoreboard predicts every write (address, data, select) from the image bytes and compares each acknowledged write against it. The bench also counts SPI clock highs seen during a pending bus cycle and requires that count to be zero.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;

  typedef enum logic [2:0] {
    ST_BOOT, ST_CMD, ST_DATA, ST_WR, ST_GAP, ST_END, ST_FAIL
  } ld_state_t;

  // append one flash byte at the low end of a big-endian accumulator
  function automatic logic [31:0] be_shift_in(input logic [31:0] w, input logic [7:0] b);
    return {w[23:0], b};
  endfunction

  // select lanes for a word carrying nbytes valid bytes, upper lanes first
  function automatic logic [3:0] lane_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    return 4'b1000;
      3'd2:    return 4'b1100;
      3'd3:    return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  // move the valid bytes of a short word up to the top lanes
  function automatic logic [31:0] left_align(input logic [31:0] w, input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    return {w[7:0], 24'h0};
      3'd2:    return {w[15:0], 16'h0};
      3'd3:    return {w[23:0], 8'h0};
      default: return w;
    endcase
  endfunction

  // command phase byte stream: read opcode, then the address MSB first
  function automatic logic [7:0] read_cmd_byte(input logic [1:0] idx, input logic [23:0] addr);
    case (idx)
      2'd0:    return 8'h03;
      2'd1:    return addr[23:16];
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/boot_spi_byte.sv
module boot_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;
  wire           tick = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      bitn  <= '0;
      sh_tx <= '0;
      sh_rx <= '0;
      sclk  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          sh_tx <= tx_byte;
          bitn  <= '0;
          cnt   <= '0;
          sclk  <= 1'b0;
        end
      end else if (tick) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn  <= bitn + 3'd1;
            sh_tx <= {sh_tx[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign mosi    = sh_tx[7];
  assign rx_byte = sh_rx;

  // R2: a new byte is only launched when the shifter is free
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/boot_hdr_capture.sv
module boot_hdr_capture #(
  parameter int HDR_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vld,
  input  logic [$clog2(HDR_BYTES)-1:0] idx,
  input  logic [7:0]                   rx,
  output logic [31:0]                  magic,
  output logic [31:0]                  pay_len,
  output logic [31:0]                  load_adr,
  output logic [31:0]                  entry_adr
);
  localparam int IW = $clog2(HDR_BYTES);

  // field f lives in header word 0 (f=0) or word f+2 (f=1..3)
  for (genvar f = 0; f < 4; f++) begin : g_fld
    localparam int WIDX = (f == 0) ? 0 : f + 2;
    logic [31:0] acc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        acc <= '0;
      else if (vld && idx[IW-1:2] == (IW-2)'(WIDX))
        acc <= {acc[23:0], rx};
    end
  end

  assign magic     = g_fld[0].acc;
  assign pay_len   = g_fld[1].acc;
  assign load_adr  = g_fld[2].acc;
  assign entry_adr = g_fld[3].acc;

endmodule

// File: rtl/boot_wb_port.sv
module boot_wb_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [31:0] adr,
  input  logic [31:0] dat,
  input  logic [3:0]  sel,
  output logic [31:0] wb_adr_o,
  output logic [31:0] wb_dat_o,
  output logic [3:0]  wb_sel_o,
  output logic        wb_we_o,
  output logic        wb_cyc_o,
  output logic        wb_stb_o,
  input  logic        wb_ack_i,
  output logic        wr_done
);
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wr_done  <= 1'b0;
      wb_adr_o <= '0;
      wb_dat_o <= '0;
      wb_sel_o <= '0;
    end else begin
      wr_done <= 1'b0;
      if (!active) begin
        if (req) begin
          active   <= 1'b1;
          wb_adr_o <= adr;
          wb_dat_o <= dat;
          wb_sel_o <= sel;
        end
      end else if (wb_ack_i) begin
        active  <= 1'b0;
        wr_done <= 1'b1;
      end
    end
  end

  assign wb_cyc_o = active;
  assign wb_stb_o = active;
  assign wb_we_o  = active;

  // R9: a stalled write keeps its address, data and lanes
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_sel_o)));

  // R6: only upper-lane-contiguous select patterns are legal
  p_sel_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb_o |-> (wb_sel_o == 4'b1111 || wb_sel_o == 4'b1110 || wb_sel_o == 4'b1100 || wb_sel_o == 4'b1000));

endmodule

// File: rtl/spi_boot_copier.sv
module spi_boot_copier
  import boot_copy_pkg::*;
#(
  parameter int          CLK_DIV    = 4,
  parameter logic [23:0] FLASH_BASE = 24'h080000,
  parameter int          HDR_BYTES  = 64,
  parameter logic [31:0] MAGIC      = 32'h27051956,
  parameter int          GAP_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [31:0] wb_adr_o,
  output logic [31:0] wb_dat_o,
  output logic [3:0]  wb_sel_o,
  output logic        wb_we_o,
  output logic        wb_cyc_o,
  output logic        wb_stb_o,
  input  logic        wb_ack_i,
  output logic        cpu_run,
  output logic [31:0] boot_vector,
  output logic        done,
  output logic        error
);
  localparam int          IW       = $clog2(HDR_BYTES);
  localparam int          GW       = $clog2(GAP_CYCLES + 1);
  localparam logic [23:0] PAY_BASE = FLASH_BASE + 24'(HDR_BYTES);

  ld_state_t     state;
  logic          phase_pay;
  logic          launched;
  logic [1:0]    cmd_idx;
  logic [31:0]   bcnt;
  logic [31:0]   word_acc;
  logic [1:0]    lane;
  logic          last_wr;
  logic [31:0]   next_adr;
  logic [GW-1:0] gap_cnt;
  logic          wr_req;
  logic [31:0]   wr_adr, wr_dat;
  logic [3:0]    wr_sel;
  logic          done_r, err_r, run_r;

  logic          eng_start, eng_busy, eng_done;
  logic [7:0]    eng_tx, eng_rx;
  logic          wr_done;
  logic [31:0]   hdr_magic, hdr_len, hdr_load, hdr_entry;

  // named internal events
  wire         xfer_state   = (state == ST_CMD) || (state == ST_DATA);
  wire         hdr_byte_evt = eng_done && (state == ST_DATA) && !phase_pay;
  wire         pay_byte_evt = eng_done && (state == ST_DATA) && phase_pay;
  wire [2:0]   fill         = {1'b0, lane} + 3'd1;
  wire         last_pay     = (bcnt == hdr_len - 32'd1);
  wire         flush_evt    = pay_byte_evt && (fill == 3'd4 || last_pay);
  wire         hdr_last     = (bcnt == 32'(HDR_BYTES - 1));
  wire         gap_end      = (state == ST_GAP) && (gap_cnt == GW'(GAP_CYCLES - 1));
  wire [31:0]  acc_next     = be_shift_in(word_acc, eng_rx);

  assign eng_start = xfer_state && !launched && !eng_busy;
  assign eng_tx    = read_cmd_byte(cmd_idx, phase_pay ? PAY_BASE : FLASH_BASE);

  boot_spi_byte #(.HALF_DIV(CLK_DIV)) u_spi (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx)
  );

  boot_hdr_capture #(.HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk(clk), .rst_n(rst_n), .vld(hdr_byte_evt), .idx(bcnt[IW-1:0]), .rx(eng_rx),
    .magic(hdr_magic), .pay_len(hdr_len), .load_adr(hdr_load), .entry_adr(hdr_entry)
  );

  boot_wb_port u_wb (
    .clk(clk), .rst_n(rst_n), .req(wr_req), .adr(wr_adr), .dat(wr_dat), .sel(wr_sel),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o), .wb_we_o(wb_we_o),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i), .wr_done(wr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      phase_pay <= 1'b0;
      launched  <= 1'b0;
      cmd_idx   <= '0;
      bcnt      <= '0;
      word_acc  <= '0;
      lane      <= '0;
      last_wr   <= 1'b0;
      next_adr  <= '0;
      gap_cnt   <= '0;
      wr_req    <= 1'b0;
      wr_adr    <= '0;
      wr_dat    <= '0;
      wr_sel    <= '0;
      done_r    <= 1'b0;
      err_r     <= 1'b0;
      run_r     <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      if (eng_start)     launched <= 1'b1;
      else if (eng_done) launched <= 1'b0;

      case (state)
        ST_BOOT: begin
          state   <= ST_CMD;
          cmd_idx <= '0;
        end
        ST_CMD: if (eng_done) begin
          cmd_idx <= cmd_idx + 2'd1;
          if (cmd_idx == 2'd3) begin
            state <= ST_DATA;
            bcnt  <= '0;
            lane  <= '0;
          end
        end
        ST_DATA: if (eng_done) begin
          bcnt <= bcnt + 32'd1;
          if (!phase_pay) begin
            if (hdr_last) begin
              state   <= ST_GAP;
              gap_cnt <= '0;
            end
          end else begin
            word_acc <= acc_next;
            if (flush_evt) begin
              wr_req  <= 1'b1;
              wr_adr  <= next_adr;
              wr_dat  <= left_align(acc_next, fill);
              wr_sel  <= lane_mask(fill);
              last_wr <= last_pay;
              lane    <= '0;
              state   <= ST_WR;
            end else begin
              lane <= lane + 2'd1;
            end
          end
        end
        ST_WR: if (wr_done) begin
          next_adr <= next_adr + 32'd4;
          state    <= last_wr ? ST_END : ST_DATA;
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt + GW'(1);
          if (gap_end) begin
            if (hdr_magic != MAGIC) begin
              state <= ST_FAIL;
              err_r <= 1'b1;
            end else if (hdr_len == 32'd0) begin
              state <= ST_END;
            end else begin
              phase_pay <= 1'b1;
              cmd_idx   <= '0;
              next_adr  <= hdr_load;
              state     <= ST_CMD;
            end
          end
        end
        ST_END: begin
          done_r <= 1'b1;
          run_r  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign spi_cs_n    = !((state == ST_CMD) || (state == ST_DATA) || (state == ST_WR));
  assign done        = done_r;
  assign error       = err_r;
  assign cpu_run     = run_r;
  assign boot_vector = hdr_entry;

  // R2: the SPI clock rests low whenever the flash is deselected (mode 0)
  p_cs_mode0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R3: a failed signature never lets the processor or the bus move
  p_fail_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!cpu_run && !done && !wb_cyc_o && spi_cs_n));

  // R9: the SPI clock is frozen low with select held during a write
  p_spi_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> (!spi_sclk && !spi_cs_n));

  // R7: completion is sticky
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && cpu_run));

  // R8: bus writes happen only in the payload phase
  p_wr_payload_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> phase_pay);

endmodule

// File: tb/tb_spi_boot_copier.sv
module tb_spi_boot_copier;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [31:0] wb_adr_o, wb_dat_o;
  logic [3:0]  wb_sel_o;
  logic        wb_we_o, wb_cyc_o, wb_stb_o;
  logic        wb_ack_i = 1'b0;
  logic        cpu_run, done, error;
  logic [31:0] boot_vector;

  always #4 clk = ~clk;

  spi_boot_copier #(.CLK_DIV(2)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o),
    .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i),
    .cpu_run(cpu_run), .boot_vector(boot_vector), .done(done), .error(error)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]  fmem [0:255];
  int          fbit;
  logic [31:0] fshift;
  int          nsess;
  logic [7:0]  sess_cmd [0:3];
  logic [23:0] sess_adr [0:3];

  initial begin
    fbit = 0; fshift = '0; nsess = 0;
    forever begin
      @(spi_sclk or spi_cs_n);
      if (spi_cs_n) begin
        fbit = 0;
      end else if (spi_sclk) begin
        if (fbit < 32) fshift = {fshift[30:0], spi_mosi};
        fbit++;
        if (fbit == 32 && nsess < 4) begin
          sess_cmd[nsess] = fshift[31:24];
          sess_adr[nsess] = fshift[23:0];
          nsess++;
        end
      end else if (fbit >= 32) begin
        int idx;
        int off;
        idx = fbit - 32;
        off = int'(fshift[23:0]) - 32'h80000 + idx / 8;
        if (off >= 0 && off < 256) spi_miso = fmem[off][7 - idx % 8];
        else spi_miso = 1'b0;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic [31:0] adr;
    logic [31:0] dat;
    logic [3:0]  sel;
  } wr_item_t;

  wr_item_t exp_q[$];
  int       ack_dly = 0;
  int       nwrites = 0;
  int       stall_sclk = 0;

  task automatic push_expected(input int len, input logic [31:0] load);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      wr_item_t it;
      it.adr = load + 32'(4 * w);
      it.dat = '0;
      it.sel = '0;
      for (int b = 0; b < 4; b++) begin
        if (w * 4 + b < len) begin
          it.dat[31 - 8 * b -: 8] = fmem[64 + w * 4 + b];
          it.sel[3 - b] = 1'b1;
        end
      end
      exp_q.push_back(it);
    end
  endtask

  // bus slave and monitor, acting between clock edges
  initial begin
    int wait_cnt;
    wr_item_t held;
    wait_cnt = 0;
    held = '0;
    forever begin
      @(negedge clk);
      cycles++;
      if (wb_cyc_o && spi_sclk) stall_sclk++;
      if (wb_ack_i) begin
        wb_ack_i = 1'b0;
      end else if (wb_cyc_o && wb_stb_o) begin
        if (wait_cnt == 0) held = '{wb_adr_o, wb_dat_o, wb_sel_o};
        else check("R9 stall hold", {wb_adr_o ^ held.adr} | {wb_dat_o ^ held.dat} | 32'(wb_sel_o ^ held.sel), 32'h0);
        if (wait_cnt >= ack_dly) begin
          wr_item_t e;
          wb_ack_i = 1'b1;
          wait_cnt = 0;
          nwrites++;
          if (exp_q.size() == 0) begin
            check("R5 unexpected write", wb_adr_o, 32'hFFFF_FFFF);
          end else begin
            e = exp_q.pop_front();
            check("R5 write address", wb_adr_o, e.adr);
            check("R5/R6 write data", wb_dat_o, e.dat);
            check("R6 write select", 32'(wb_sel_o), 32'(e.sel));
            check("R9 write enable", 32'(wb_we_o), 32'h1);
          end
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  task automatic load_image(input logic [31:0] magic, input int len,
                            input logic [31:0] load, input logic [31:0] entry, input int seed);
    for (int i = 0; i < 256; i++) fmem[i] = 8'(seed + i * 29 + 3);
    for (int i = 0; i < 64; i++) if (i >= 4) fmem[i] = 8'h00;
    for (int b = 0; b < 4; b++) begin
      fmem[b]      = magic[31 - 8 * b -: 8];
      fmem[12 + b] = 8'(len >> (24 - 8 * b));
      fmem[16 + b] = load[31 - 8 * b -: 8];
      fmem[20 + b] = entry[31 - 8 * b -: 8];
    end
  endtask

  task automatic run_case(input string name, input int dly, input bit good, input int len,
                          input logic [31:0] load, input logic [31:0] entry);
    @(negedge clk);
    rst_n = 1'b0;
    ack_dly = dly;
    nwrites = 0;
    stall_sclk = 0;
    exp_q.delete();
    if (good) push_expected(len, load);
    repeat (3) @(negedge clk);
    check("R1 reset cs_n", 32'(spi_cs_n), 32'h1);
    check("R1 reset sclk", 32'(spi_sclk), 32'h0);
    check("R1 reset flags", {29'h0, done, error, cpu_run}, 32'h0);
    check("R1 reset cyc", 32'(wb_cyc_o), 32'h0);
    nsess = 0;
    rst_n = 1'b1;
    for (int t = 0; t < 40000 && !(done || error); t++) @(negedge clk);
    repeat (20) @(negedge clk);
    $display("case %s", name);
    check("R2 header command", 32'(sess_cmd[0]), 32'h03);
    check("R2 header address", 32'(sess_adr[0]), 32'h080000);
    check("R9 sclk frozen in write", 32'(stall_sclk), 32'h0);
    check("R3/R8 pending writes", 32'(exp_q.size()), 32'h0);
    check("R2/R3 cs released", 32'(spi_cs_n), 32'h1);
    if (!good) begin
      check("R3 error", 32'(error), 32'h1);
      check("R3 done low", 32'(done), 32'h0);
      check("R3 cpu held", 32'(cpu_run), 32'h0);
      check("R3 no writes", 32'(nwrites), 32'h0);
      check("R3 one session", 32'(nsess), 32'h1);
    end else begin
      check("R7 done", 32'(done), 32'h1);
      check("R7 cpu_run", 32'(cpu_run), 32'h1);
      check("R7 error low", 32'(error), 32'h0);
      check("R7 boot vector", boot_vector, entry);
      check("R5 write count", 32'(nwrites), 32'((len + 3) / 4));
      if (len == 0) begin
        check("R8 no payload session", 32'(nsess), 32'h1);
      end else begin
        check("R4 two sessions", 32'(nsess), 32'h2);
        check("R4 payload command", 32'(sess_cmd[1]), 32'h03);
        check("R4 payload address", 32'(sess_adr[1]), 32'h080040);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset at start cs_n", 32'(spi_cs_n), 32'h1);
    check("R1 reset at start cyc", 32'(wb_cyc_o), 32'h0);

    load_image(32'h27051956, 24, 32'h100, 32'h100, 11);
    run_case("sample 24B", 0, 1'b1, 24, 32'h100, 32'h100);

    load_image(32'h27051956, 7, 32'h2000, 32'h2040, 5);
    run_case("partial 3B tail, slow ack", 3, 1'b1, 7, 32'h2000, 32'h2040);

    load_image(32'h27051956, 5, 32'h40, 32'h44, 77);
    run_case("partial 1B tail", 1, 1'b1, 5, 32'h40, 32'h44);

    load_image(32'h27051956, 6, 32'h800, 32'h800, 200);
    run_case("partial 2B tail", 0, 1'b1, 6, 32'h800, 32'h800);

    load_image(32'h27051957, 8, 32'h100, 32'h100, 9);
    run_case("bad magic", 0, 1'b0, 8, 32'h100, 32'h100);

    load_image(32'h27051956, 0, 32'h100, 32'h1234, 3);
    run_case("zero length", 0, 1'b1, 0, 32'h100, 32'h1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule